// File: doc/BRIEF.md
# Four-Channel Compare-Match PWM Timer

This block is a peripheral that holds four independent 16-bit timer channels. Each channel drives one output pin. A channel counts ticks derived from a shared external count input. It selects which edge of that input counts, and divides the selected edges by 1, 4, 16 or 64. Its counter can be cleared by a match against any one of four general compare registers. In PWM mode the pin restarts at a programmed level on every counter clear and takes a programmed action when the counter reaches compare register A. This gives a period set by the clear register and a duty set by register A.

Software reaches the block through a simple 16-bit register bus. Writes are single-cycle; reads are combinational. One shared run register holds one bit per channel. Every channel has its own bank of ten registers: control, mode, pin control, interrupt enable, status, counter and four compare registers. A stopped channel keeps its counter value. Its pin follows the initial level written to pin control, so software can hold a fixed 0% or 100% level without running the counter. Compare matches are kept as status flags. A single interrupt line is the OR of all flags whose enable bit is set.

Top module: `pwm_timer_bank`

## Requirements
- R1: Bit n of the run register at address 0x000 runs channel n. While that bit is 0 the channel's counter keeps its value, apart from direct counter writes.
- R2: Channel n's bank starts at address 0x010 + 0x40*n. Inside a bank the offsets are: counter 0x14, compare registers A/B/C/D 0x18/0x1C/0x20/0x24, control 0x00, status 0x10, pin control 0x08, mode 0x04, interrupt enable 0x0C. Every register reads back what was last written or counted.
- R3: Control bits [4:3] choose the counted edge of tick_in: 0 rising, 1 falling, 2 or 3 both. Control bits [1:0] = p make the counter advance once every 4^p selected edges.
- R4: Control bits [7:5] choose the clear register: 1 = A, 2 = B, 5 = C, 6 = D, any other value = none. When the counter equals the clear register, the next tick loads 0. Otherwise a tick adds 1, wrapping from 0xFFFF to 0.
- R5: With mode bits [1:0] = 2 (PWM), the pin takes pin-control bit 2 when the counter clears. When the counter reaches compare A, the pin takes the pin-control bits [1:0] action: 0 keep, 1 low, 2 high, 3 invert.
- R6: With mode bits [1:0] = 0 (normal), the compare-A action still applies, but a counter clear does not restore the pin level.
- R7: A write to pin control while the channel is stopped drives the pin at once to the written bit 2.
- R8: A tick that brings the counter to the value of compare register A, B, C or D sets status bit 0, 1, 2 or 3. A status write clears the bits written as 0 and keeps those written as 1; a new match wins over the clear.
- R9: Output irq is high exactly when some channel has a status bit set whose bit in the same position of its interrupt-enable register is also set.
- R10: A write to a compare register takes effect at once. The exceptions are mode bit 4, which reloads A from C on each counter clear, and mode bit 5, which reloads B from D.
- R11: Reset clears every register, the counters and the pins; irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational |
| tick_in | input | 1 | External count input, edges are counted |
| pin_out | output | NCH | One waveform pin per channel |
| irq | output | 1 | OR of enabled status flags |

## Verification
A wrong counter or clear decode shows up within one PWM period as a changed number of pin-high cycles or pin rising edges in a window of whole periods. The tests compare those counts for several period, duty, prescale, clear-source and polarity settings. A fault in the run gating or the edge selection shows up in the counter read back after a known number of clock edges. Status, interrupt and buffer-reload faults show up on the bus or on irq directly after a short run of a few periods.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  localparam int BANK_LG = 6;
  localparam int NGR     = 4;

  localparam logic [5:0] OFS_CTL  = 6'h00;
  localparam logic [5:0] OFS_MODE = 6'h04;
  localparam logic [5:0] OFS_IO   = 6'h08;
  localparam logic [5:0] OFS_IER  = 6'h0C;
  localparam logic [5:0] OFS_STAT = 6'h10;
  localparam logic [5:0] OFS_CNT  = 6'h14;
  localparam logic [5:0] OFS_GRA  = 6'h18;

  localparam logic [1:0] MODE_PWM = 2'd2;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_ALSO = 2'd3
  } edge_sel_e;

  // clear-source field to one-hot over compare registers A..D
  function automatic logic [3:0] clr_decode(input logic [2:0] f);
    case (f)
      3'd1:    clr_decode = 4'b0001;
      3'd2:    clr_decode = 4'b0010;
      3'd5:    clr_decode = 4'b0100;
      3'd6:    clr_decode = 4'b1000;
      default: clr_decode = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/ptb_edge_div.sv
module ptb_edge_div
  import ptb_pkg::*;
#(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rise,
  input  logic             fall,
  input  logic [1:0]       edge_sel,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  localparam int PW = 2 * ((1 << PSC_W) - 1);

  logic [PW-1:0] pre_q, pre_d, mask;
  logic          hit, pre_en;

  always_comb begin
    case (edge_sel_e'(edge_sel))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      default:   hit = rise | fall;
    endcase
    mask   = ~({PW{1'b1}} << (2 * psc));
    tick   = run & hit & ((pre_q & mask) == mask);
    pre_en = !run | hit;
    pre_d  = run ? pre_q + PW'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end
endmodule

// File: rtl/ptb_channel.sv
module ptb_channel
  import ptb_pkg::*;
#(
  parameter int DW    = 16,
  parameter int PSC_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          rise,
  input  logic          fall,
  input  logic          sel,
  input  logic          wr,
  input  logic [5:0]    ofs,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          pin,
  output logic          irq_req,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] ctl_o,
  output logic [DW-1:0] mode_o,
  output logic [DW-1:0] io_o,
  output logic [DW-1:0] ier_o,
  output logic [DW-1:0] gra_o,
  output logic [DW-1:0] grb_o,
  output logic [3:0]    stat_o,
  output logic          tick_o,
  output logic          cnt_wr_o,
  output logic          stat_wr_o
);
  logic [DW-1:0] ctl_q, mode_q, io_q, ier_q, cnt_q, cnt_d, cnt_nx;
  logic [DW-1:0] gr_q [NGR];
  logic [DW-1:0] gr_d [NGR];
  logic [NGR-1:0] w_gr, gr_en;
  logic [3:0] stat_q, stat_d, eq, hit_nx, clr_oh;
  logic pin_q, pin_d, tick, wr_hit;
  logic w_ctl, w_mode, w_io, w_ier, w_stat, w_cnt;
  logic cnt_en, stat_en, clr_hit, adv, wrap, pwm, base;

  ptb_edge_div #(.PSC_W(PSC_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .rise     (rise),
    .fall     (fall),
    .edge_sel (ctl_q[4:3]),
    .psc      (ctl_q[PSC_W-1:0]),
    .tick     (tick)
  );

  // write decode
  always_comb begin
    wr_hit = sel & wr;
    w_ctl  = wr_hit && (ofs == OFS_CTL);
    w_mode = wr_hit && (ofs == OFS_MODE);
    w_io   = wr_hit && (ofs == OFS_IO);
    w_ier  = wr_hit && (ofs == OFS_IER);
    w_stat = wr_hit && (ofs == OFS_STAT);
    w_cnt  = wr_hit && (ofs == OFS_CNT);
    for (int i = 0; i < NGR; i++) w_gr[i] = wr_hit && (ofs == OFS_GRA + 6'(4 * i));
  end

  // counter, compare and clear
  always_comb begin
    clr_oh = clr_decode(ctl_q[7:5]);
    for (int i = 0; i < NGR; i++) eq[i] = (cnt_q == gr_q[i]);
    clr_hit = |(clr_oh & eq);
    cnt_nx  = clr_hit ? '0 : cnt_q + DW'(1);
    adv     = tick & ~w_cnt;
    wrap    = adv & clr_hit;
    for (int i = 0; i < NGR; i++) hit_nx[i] = adv & (cnt_nx == gr_q[i]);
    cnt_d   = w_cnt ? wdata : cnt_nx;
    cnt_en  = w_cnt | tick;
    stat_d  = (w_stat ? (stat_q & wdata[3:0]) : stat_q) | hit_nx;
    stat_en = w_stat | (|hit_nx);
  end

  // compare registers with optional reload from C/D on clear
  always_comb begin
    for (int i = 0; i < NGR; i++) begin
      gr_d[i]  = w_gr[i] ? wdata : gr_q[i];
      gr_en[i] = w_gr[i];
    end
    if (!w_gr[0] && mode_q[4] && wrap) begin
      gr_d[0]  = gr_q[2];
      gr_en[0] = 1'b1;
    end
    if (!w_gr[1] && mode_q[5] && wrap) begin
      gr_d[1]  = gr_q[3];
      gr_en[1] = 1'b1;
    end
  end

  // pin output
  always_comb begin
    pwm  = (mode_q[1:0] == MODE_PWM);
    base = (pwm && wrap) ? io_q[2] : pin_q;
    pin_d = base;
    if (hit_nx[0]) begin
      case (io_q[1:0])
        2'd0:    pin_d = base;
        2'd1:    pin_d = 1'b0;
        2'd2:    pin_d = 1'b1;
        default: pin_d = ~base;
      endcase
    end
    if (!run && w_io) pin_d = wdata[2];
  end

  // read mux
  always_comb begin
    case (ofs)
      OFS_CTL:        rdata = ctl_q;
      OFS_MODE:       rdata = mode_q;
      OFS_IO:         rdata = io_q;
      OFS_IER:        rdata = ier_q;
      OFS_STAT:       rdata = {{(DW-4){1'b0}}, stat_q};
      OFS_CNT:        rdata = cnt_q;
      OFS_GRA:        rdata = gr_q[0];
      OFS_GRA + 6'd4: rdata = gr_q[1];
      OFS_GRA + 6'd8: rdata = gr_q[2];
      OFS_GRA + 6'd12: rdata = gr_q[3];
      default:        rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (w_ctl) ctl_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= '0;
    else if (w_mode) mode_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    io_q <= '0;
    else if (w_io) io_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ier_q <= '0;
    else if (w_ier) ier_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  for (genvar g = 0; g < NGR; g++) begin : g_gr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gr_q[g] <= '0;
      else if (gr_en[g]) gr_q[g] <= gr_d[g];
    end
  end

  assign pin       = pin_q;
  assign irq_req   = |(stat_q & ier_q[3:0]);
  assign cnt_o     = cnt_q;
  assign ctl_o     = ctl_q;
  assign mode_o    = mode_q;
  assign io_o      = io_q;
  assign ier_o     = ier_q;
  assign gra_o     = gr_q[0];
  assign grb_o     = gr_q[1];
  assign stat_o    = stat_q;
  assign tick_o    = tick;
  assign cnt_wr_o  = w_cnt;
  assign stat_wr_o = w_stat;
endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import ptb_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int DW        = 16,
  parameter int ADDR_W    = 9,
  parameter int BANK_BASE = 16,
  parameter int PSC_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              tick_in,
  output logic [NCH-1:0]    pin_out,
  output logic              irq
);
  localparam int CHW  = ADDR_W - BANK_LG;
  localparam int SPAN = NCH << BANK_LG;

  logic [NCH-1:0] start_q, start_d;
  logic start_en, tick_prev_q, rise, fall, in_bank;
  logic [ADDR_W-1:0] bank_ofs;
  logic [CHW-1:0] ch_idx;
  logic [NCH-1:0] ch_sel, irq_req;
  logic [NCH-1:0][DW-1:0] ch_rdata;

  logic [NCH-1:0][DW-1:0] cnt_all, ctl_all, mode_all, io_all, ier_all, gra_all, grb_all;
  logic [NCH-1:0][3:0]    stat_all;
  logic [NCH-1:0]         tick_all, cnt_wr, stat_wr;

  always_comb begin
    bank_ofs = bus_addr - ADDR_W'(BANK_BASE);
    in_bank  = (bus_addr >= ADDR_W'(BANK_BASE)) && (bank_ofs < ADDR_W'(SPAN));
    ch_idx   = bank_ofs[ADDR_W-1:BANK_LG];
    for (int n = 0; n < NCH; n++) ch_sel[n] = bus_sel && in_bank && (ch_idx == CHW'(n));
    start_en = bus_sel && bus_wr && (bus_addr == '0);
    start_d  = bus_wdata[NCH-1:0];
    rise     = tick_in & ~tick_prev_q;
    fall     = ~tick_in & tick_prev_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) bus_rdata = DW'(start_q);
    for (int n = 0; n < NCH; n++) if (ch_sel[n]) bus_rdata = ch_rdata[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        start_q <= '0;
    else if (start_en) start_q <= start_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_prev_q <= 1'b0;
    else        tick_prev_q <= tick_in;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ptb_channel #(.DW(DW), .PSC_W(PSC_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (start_q[g]),
      .rise      (rise),
      .fall      (fall),
      .sel       (ch_sel[g]),
      .wr        (bus_wr),
      .ofs       (bank_ofs[BANK_LG-1:0]),
      .wdata     (bus_wdata),
      .rdata     (ch_rdata[g]),
      .pin       (pin_out[g]),
      .irq_req   (irq_req[g]),
      .cnt_o     (cnt_all[g]),
      .ctl_o     (ctl_all[g]),
      .mode_o    (mode_all[g]),
      .io_o      (io_all[g]),
      .ier_o     (ier_all[g]),
      .gra_o     (gra_all[g]),
      .grb_o     (grb_all[g]),
      .stat_o    (stat_all[g]),
      .tick_o    (tick_all[g]),
      .cnt_wr_o  (cnt_wr[g]),
      .stat_wr_o (stat_wr[g])
    );
  end

  assign irq = |irq_req;
endmodule

// File: rtl/ptb_chk.sv
module ptb_chk #(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         start_q,
  input logic [NCH-1:0][DW-1:0] cnt_all,
  input logic [NCH-1:0][DW-1:0] ctl_all,
  input logic [NCH-1:0][DW-1:0] mode_all,
  input logic [NCH-1:0][DW-1:0] io_all,
  input logic [NCH-1:0][DW-1:0] ier_all,
  input logic [NCH-1:0][DW-1:0] gra_all,
  input logic [NCH-1:0][DW-1:0] grb_all,
  input logic [NCH-1:0][3:0]    stat_all,
  input logic [NCH-1:0]         tick_all,
  input logic [NCH-1:0]         cnt_wr,
  input logic [NCH-1:0]         stat_wr,
  input logic [NCH-1:0]         pin_out,
  input logic                   irq
);
  for (genvar g = 0; g < NCH; g++) begin : g_p
    p_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_q[g] && !cnt_wr[g]) |=> $stable(cnt_all[g]));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_all[g] && !cnt_wr[g] && ctl_all[g][7:5] == 3'd2 && cnt_all[g] == grb_all[g])
      |=> (cnt_all[g] == '0));

    p_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_all[g] && !cnt_wr[g] && mode_all[g][1:0] == 2'd2 && ctl_all[g][7:5] == 3'd2
       && cnt_all[g] == grb_all[g] && gra_all[g] != '0)
      |=> (pin_out[g] == $past(io_all[g][2])));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_all[g][0] && !stat_wr[g]) |=> stat_all[g][0]);
  end

  p_quiet_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_all == '0) |-> !irq);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r11: assert (pin_out == '0 && !irq);
    end
  end
endmodule

bind pwm_timer_bank ptb_chk #(.NCH(NCH), .DW(DW)) u_ptb_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_q  (start_q),
  .cnt_all  (cnt_all),
  .ctl_all  (ctl_all),
  .mode_all (mode_all),
  .io_all   (io_all),
  .ier_all  (ier_all),
  .gra_all  (gra_all),
  .grb_all  (grb_all),
  .stat_all (stat_all),
  .tick_all (tick_all),
  .cnt_wr   (cnt_wr),
  .stat_wr  (stat_wr),
  .pin_out  (pin_out),
  .irq      (irq)
);

// File: tb/pwm_timer_bank_bench.sv
`timescale 1ns/1ps
module pwm_timer_bank_bench;
  localparam int DW = 16, NCH = 4, AW = 9;
  localparam int O_CTL = 'h00, O_MODE = 'h04, O_IO = 'h08, O_IER = 'h0C, O_STAT = 'h10,
                 O_CNT = 'h14, O_GA = 'h18, O_GB = 'h1C, O_GC = 'h20, O_GD = 'h24;

  // {clear field, prescale, pin control, compare A, period register value}
  localparam logic [40:0] VEC [6] = '{
    {3'd2, 2'd0, 4'h5, 16'd3, 16'd9},
    {3'd2, 2'd0, 4'h2, 16'd5, 16'd7},
    {3'd5, 2'd1, 4'h5, 16'd2, 16'd5},
    {3'd6, 2'd2, 4'h2, 16'd1, 16'd3},
    {3'd2, 2'd0, 4'h7, 16'd6, 16'd10},
    {3'd2, 2'd3, 4'h5, 16'd1, 16'd2}
  };

  logic clk, rst_n, bus_sel, bus_wr, tick_in, irq;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata, rv;
  logic [NCH-1:0] pin_out;
  int n_chk, n_fail;
  logic [2:0] v_clr;
  logic [1:0] v_psc;
  logic [3:0] v_io;
  logic [15:0] v_a, v_p;
  int unit, per, exp_hi, hi, rs, p_ofs;

  pwm_timer_bank u_pwm_timer_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in),
    .pin_out(pin_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    tick_in = 1'b0;
    forever begin
      @(negedge clk);
      tick_in = ~tick_in;
    end
  end

  function automatic logic [AW-1:0] ra(input int ch, input int ofs);
    return AW'(16 + ch * 64 + ofs);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int ch, input int win, output int highs, output int rises);
    logic prev;
    prev = pin_out[ch];
    highs = 0; rises = 0;
    repeat (win) begin
      @(negedge clk);
      if (pin_out[ch]) highs++;
      if (pin_out[ch] && !prev) rises++;
      prev = pin_out[ch];
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 run hung actual=running expected=finished");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd('0, rv);              chk("R11 run register", rv, 0);
    rd(ra(0, O_CTL), rv);    chk("R11 control", rv, 0);
    chk("R11 pins", pin_out, 0);
    chk("R11 irq", irq, 0);

    // R2 address map and readback
    wr(ra(2, O_GC), 16'hBEEF);
    rd(ra(2, O_GC), rv);     chk("R2 ch2 compare C", rv, 'hBEEF);
    rd(ra(0, O_GC), rv);     chk("R2 ch0 compare C untouched", rv, 0);
    wr(ra(0, O_GA), 16'h1234);
    rd(ra(0, O_GA), rv);     chk("R10 immediate compare write", rv, 'h1234);

    // R7 stopped pin-control write
    wr(ra(1, O_IO), 16'h0004); chk("R7 pin to 1", pin_out[1], 1);
    wr(ra(1, O_IO), 16'h0000); chk("R7 pin to 0", pin_out[1], 0);

    // R1 counter runs only while its run bit is set
    wr(ra(0, O_CTL), 16'h0010);
    wr(ra(0, O_MODE), 16'h0000);
    wr(ra(0, O_CNT), 16'd100);
    wr('0, 16'h0001);
    repeat (4) @(negedge clk);
    wr('0, 16'h0000);
    rd(ra(0, O_CNT), rv);    chk("R1 count while running", rv, 105);
    repeat (5) @(negedge clk);
    rd(ra(0, O_CNT), rv);    chk("R1 frozen while stopped", rv, 105);

    // R4 free-running wrap
    wr(ra(0, O_CNT), 16'hFFFE);
    wr('0, 16'h0001);
    @(negedge clk);
    wr('0, 16'h0000);
    rd(ra(0, O_CNT), rv);    chk("R4 wrap past 0xFFFF", rv, 0);

    // R3 rising edge only
    wr(ra(0, O_CTL), 16'h0000);
    wr(ra(0, O_CNT), 16'd0);
    wr('0, 16'h0001);
    repeat (9) @(negedge clk);
    wr('0, 16'h0000);
    rd(ra(0, O_CNT), rv);    chk("R3 rising edges only", rv, 5);

    // vector table: PWM waveform for several settings (R3 R4 R5)
    for (int v = 0; v < 6; v++) begin
      {v_clr, v_psc, v_io, v_a, v_p} = VEC[v];
      wr('0, 16'h0000);
      wr(ra(0, O_CTL), 16'((int'(v_clr) << 5) | (2 << 3) | int'(v_psc)));
      wr(ra(0, O_MODE), 16'h0002);
      wr(ra(0, O_IO), 16'(v_io));
      wr(ra(0, O_CNT), 16'd0);
      wr(ra(0, O_GA), v_a);
      p_ofs = (v_clr == 3'd2) ? O_GB : (v_clr == 3'd5) ? O_GC : O_GD;
      wr(ra(0, p_ofs), v_p);
      wr('0, 16'h0001);
      unit   = 1 << (2 * int'(v_psc));
      per    = (int'(v_p) + 1) * unit;
      exp_hi = v_io[2] ? 4 * int'(v_a) * unit : 4 * (int'(v_p) + 1 - int'(v_a)) * unit;
      repeat (per) @(negedge clk);
      measure(0, 4 * per, hi, rs);
      chk($sformatf("R5 vector %0d high cycles", v), hi, exp_hi);
      chk($sformatf("R4 vector %0d periods", v), rs, 4);
    end

    // R6 normal mode: toggle on A, no restore on clear
    wr('0, 16'h0000);
    wr(ra(0, O_IO), 16'h0003);
    wr(ra(0, O_CTL), 16'h0050);
    wr(ra(0, O_MODE), 16'h0000);
    wr(ra(0, O_GA), 16'd1);
    wr(ra(0, O_GB), 16'd3);
    wr(ra(0, O_CNT), 16'd0);
    wr('0, 16'h0001);
    repeat (8) @(negedge clk);
    measure(0, 32, hi, rs);
    chk("R6 normal toggle high cycles", hi, 16);
    chk("R6 normal toggle rises", rs, 4);

    // R8 status flags
    wr('0, 16'h0000);
    wr(ra(0, O_STAT), 16'h0000);
    wr(ra(0, O_MODE), 16'h0002);
    wr(ra(0, O_IO), 16'h0005);
    wr(ra(0, O_GA), 16'd3);
    wr(ra(0, O_GB), 16'd9);
    wr(ra(0, O_GC), 16'h1000);
    wr(ra(0, O_GD), 16'h1000);
    wr(ra(0, O_CNT), 16'd0);
    wr('0, 16'h0001);
    repeat (25) @(negedge clk);
    wr('0, 16'h0000);
    rd(ra(0, O_STAT), rv);   chk("R8 flags A and B set", rv, 3);
    wr(ra(0, O_STAT), 16'h0002);
    rd(ra(0, O_STAT), rv);   chk("R8 write-zero clears", rv, 2);

    // R9 interrupt gating
    chk("R9 irq with no enables", irq, 0);
    wr(ra(0, O_IER), 16'h0002); chk("R9 irq enabled flag", irq, 1);
    wr(ra(0, O_IER), 16'h0001); chk("R9 irq flag not enabled", irq, 0);

    // R10 buffered reload of A from C
    wr(ra(0, O_MODE), 16'h0012);
    wr(ra(0, O_GA), 16'd2);
    wr(ra(0, O_GC), 16'd6);
    wr(ra(0, O_CNT), 16'd0);
    wr('0, 16'h0001);
    repeat (25) @(negedge clk);
    wr('0, 16'h0000);
    rd(ra(0, O_GA), rv);     chk("R10 A reloaded from C", rv, 6);

    finish_run();
  end
endmodule